// File: doc/BRIEF.md
# Two-Section Data Translation Buffer

The block holds address translations for the data side of a processor in two sections. A pinned section of four entries is written only by explicit inserts. A replaceable cache section of eight entries can also be cleared by purge commands. Each entry records a region identifier, the virtual address of its page, a two-bit page-size code, a valid bit and two 64-bit translation words. Software-style commands write an entry into a named slot of either section. They also remove cache entries that overlap a region/address/size triple.

Two read ports work combinationally on the current contents. The key port returns the protection key of the entry that matches an address and region. It places the key in a fixed bit field and returns the sentinel value 1 when there is no usable match. The promotion port applies the privilege-promotion rule to the matching entry and returns the resulting privilege level.

Commands are single-cycle strobes that are always accepted, so there is no back-pressure. An insert or purge presented in a cycle takes effect at the next rising clock edge, and the read ports see the new contents from then on.

Top module: `xlat_buffer`

## Requirements
- R1: A synchronous reset clears every valid bit in both sections, after which every key lookup returns 1.
- R2: An insert writes the pinned section when `ins_tr` is 1, using slot `ins_slot[1:0]`. When `ins_tr` is 0 it writes the cache section, using slot `ins_slot[2:0]`. The write overwrites the slot unconditionally and is visible after the next rising edge.
- R3: Translation word layout. Word 0 holds present in bit 0, privilege level in bits 8:7 and access rights in bits 11:9. Word 1 holds the page-size code in bits 1:0 and the protection key in bits 31:8. The size codes are 0 = 4 KB, 1 = 16 KB, 2 = 64 KB and 3 = 1 MB.
- R4: An entry matches a query when it is valid, its present bit is 1, its region equals the query region, and all address bits at or above its page-size boundary are equal.
- R5: On a match, the key result carries the entry's key in bits 31:8, and all other bits of the 64-bit result are zero.
- R6: The key result is 1 when no entry matches, or when any address bit at or above bit 50 is set (an unimplemented address).
- R7: When several entries match, a pinned entry wins over a cache entry, and the lowest slot index wins within a section.
- R8: A purge clears the cache entries whose region equals the request and whose address agrees with the request above the larger of the two page sizes. Pinned entries are never cleared by a purge.
- R9: A purge size is given as log2 of bytes on `pg_log2sz`, and only 12, 14, 16 and 20 are supported. Any other value clears every cache entry.
- R10: When an insert and a purge arrive in the same cycle, the purge applies first, so the inserted slot ends valid.
- R11: The promotion result equals the page's level when the matching entry has access rights 7 (execute-only) and a level numerically below `pp_cur_pl`. In every other case, including no match, it equals `pp_cur_pl`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ins_en | input | 1 | Insert strobe |
| ins_tr | input | 1 | 1 selects the pinned section, 0 the cache section |
| ins_slot | input | 3 | Slot number for the insert |
| ins_va | input | 64 | Virtual address of the inserted page |
| ins_rid | input | 24 | Region identifier of the inserted page |
| ins_pte0 | input | 64 | Translation word 0 |
| ins_pte1 | input | 64 | Translation word 1 |
| pg_en | input | 1 | Purge strobe |
| pg_rid | input | 24 | Purge region identifier |
| pg_va | input | 64 | Purge virtual address |
| pg_log2sz | input | 6 | Purge size as log2 of bytes |
| lk_va | input | 64 | Key lookup address |
| lk_rid | input | 24 | Key lookup region |
| lk_key | output | 64 | Key result or the sentinel 1 |
| pp_va | input | 64 | Promotion query address |
| pp_rid | input | 24 | Promotion query region |
| pp_cur_pl | input | 2 | Current privilege level |
| pp_new_pl | output | 2 | Privilege level after the promotion rule |

## Verification
A wrong valid bit, region, address or size field in the store shows at the key port as soon as the edge that wrote it has passed. Depending on the fault, the port returns a key where 1 was expected, returns 1 where a key was expected, or returns the key of another entry that a shadowed match exposes. Faulty purge overlap or section selection shows the same way on the cycle after the purge. Address sweeps that straddle every page-size boundary, taken after each insert and purge, therefore expose a corrupted entry within one cycle of its cause. Promotion faults appear directly as a level that differs from the rule for a given combination of rights, page level and current level.

// File: rtl/xb_pkg.sv
package xb_pkg;
  localparam int XB_VA_W    = 64;
  localparam int XB_PTE_W   = 64;
  localparam int P0_PRESENT = 0;
  localparam int P0_PL_LO   = 7;
  localparam int P0_AR_LO   = 9;
  localparam int P1_SZ_LO   = 0;
  localparam int P1_KEY_LO  = 8;
  localparam int KEY_W      = 24;
  localparam logic [2:0] AR_EXEC_ONLY = 3'd7;

  typedef logic [1:0] pgsz_t;

  // address bits that take part in a compare for a given size code
  function automatic logic [XB_VA_W-1:0] pg_mask(input pgsz_t c);
    case (c)
      2'd0:    return ~64'h0000_0000_0000_0FFF;
      2'd1:    return ~64'h0000_0000_0000_3FFF;
      2'd2:    return ~64'h0000_0000_0000_FFFF;
      default: return ~64'h0000_0000_000F_FFFF;
    endcase
  endfunction

  function automatic logic log2_ok(input logic [5:0] l2);
    return (l2 == 6'd12) || (l2 == 6'd14) || (l2 == 6'd16) || (l2 == 6'd20);
  endfunction

  function automatic pgsz_t log2_code(input logic [5:0] l2);
    case (l2)
      6'd14:   return 2'd1;
      6'd16:   return 2'd2;
      6'd20:   return 2'd3;
      default: return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/xb_store.sv
module xb_store
  import xb_pkg::*;
#(
  parameter int TR_N   = 4,
  parameter int TC_N   = 8,
  parameter int RID_W  = 24,
  parameter int SLOT_W = 3,
  parameter int N      = TR_N + TC_N
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ins_en,
  input  logic                ins_tr,
  input  logic [SLOT_W-1:0]   ins_slot,
  input  logic [XB_VA_W-1:0]  ins_va,
  input  logic [RID_W-1:0]    ins_rid,
  input  logic [XB_PTE_W-1:0] ins_pte0,
  input  logic [XB_PTE_W-1:0] ins_pte1,
  input  logic                pg_en,
  input  logic [RID_W-1:0]    pg_rid,
  input  logic [XB_VA_W-1:0]  pg_va,
  input  logic [5:0]          pg_log2sz,
  output logic [N-1:0]        e_valid,
  output logic [RID_W-1:0]    e_rid  [N],
  output logic [XB_VA_W-1:0]  e_va   [N],
  output logic [XB_PTE_W-1:0] e_pte0 [N],
  output logic [XB_PTE_W-1:0] e_pte1 [N]
);
  localparam int TRS_W = (TR_N > 1) ? $clog2(TR_N) : 1;
  localparam int TCS_W = (TC_N > 1) ? $clog2(TC_N) : 1;

  logic  pg_all;
  pgsz_t pg_code;
  logic [XB_VA_W-1:0] pg_rmask;

  assign pg_all   = pg_en && !log2_ok(pg_log2sz);
  assign pg_code  = log2_code(pg_log2sz);
  assign pg_rmask = pg_mask(pg_code);

  for (genvar e = 0; e < N; e++) begin : g_ent
    logic sel, kill;
    if (e < TR_N) begin : g_tr
      assign sel  = ins_en && ins_tr && (ins_slot[TRS_W-1:0] == TRS_W'(e));
      assign kill = 1'b0;
    end else begin : g_tc
      logic ovl;
      assign sel  = ins_en && !ins_tr && (ins_slot[TCS_W-1:0] == TCS_W'(e - TR_N));
      assign ovl  = (e_rid[e] == pg_rid) &&
                    (((pg_va ^ e_va[e]) & pg_rmask &
                      pg_mask(e_pte1[e][P1_SZ_LO +: 2])) == '0);
      assign kill = pg_all || (pg_en && ovl);
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        e_valid[e] <= 1'b0;
      end else if (sel) begin
        e_valid[e] <= 1'b1;
      end else if (kill) begin
        e_valid[e] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        e_rid[e]  <= ins_rid;
        e_va[e]   <= ins_va;
        e_pte0[e] <= ins_pte0;
        e_pte1[e] <= ins_pte1;
      end
    end
  end

  // R1
  reset_clears_chk: assert property (@(posedge clk) rst |=> (e_valid == '0));

  // R8
  tr_purge_immune_chk: assert property (@(posedge clk) disable iff (rst)
    !(ins_en && ins_tr) |=> $stable(e_valid[TR_N-1:0]));

  // R9
  bad_size_flush_chk: assert property (@(posedge clk) disable iff (rst)
    (pg_en && !log2_ok(pg_log2sz) && !(ins_en && !ins_tr)) |=> (e_valid[N-1:TR_N] == '0));

  // R2
  tr_insert_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (ins_en && ins_tr) |=> e_valid[$past(ins_slot[TRS_W-1:0])]);

  // R10
  tc_insert_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (ins_en && !ins_tr) |=> e_valid[TR_N + int'($past(ins_slot[TCS_W-1:0]))]);
endmodule

// File: rtl/xb_lookup.sv
module xb_lookup
  import xb_pkg::*;
#(
  parameter int N     = 12,
  parameter int RID_W = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N-1:0]        e_valid,
  input  logic [RID_W-1:0]    e_rid  [N],
  input  logic [XB_VA_W-1:0]  e_va   [N],
  input  logic [XB_PTE_W-1:0] e_pte0 [N],
  input  logic [XB_PTE_W-1:0] e_pte1 [N],
  input  logic [XB_VA_W-1:0]  q_va,
  input  logic [RID_W-1:0]    q_rid,
  output logic                hit,
  output logic [XB_PTE_W-1:0] pte0,
  output logic [XB_PTE_W-1:0] pte1
);
  logic [N-1:0] match;
  logic [N-1:0] grant;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign match[i] = e_valid[i] && e_pte0[i][P0_PRESENT] && (e_rid[i] == q_rid) &&
                      (((q_va ^ e_va[i]) & pg_mask(e_pte1[i][P1_SZ_LO +: 2])) == '0);
  end

  // index order puts the pinned section first, so the lowest set bit wins
  always_comb begin
    logic taken;
    taken = 1'b0;
    grant = '0;
    pte0  = '0;
    pte1  = '0;
    for (int i = 0; i < N; i++) begin
      if (match[i] && !taken) begin
        taken    = 1'b1;
        grant[i] = 1'b1;
        pte0     = e_pte0[i];
        pte1     = e_pte1[i];
      end
    end
    hit = taken;
  end

  // R7
  single_winner_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(grant));
endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer
  import xb_pkg::*;
#(
  parameter int TR_N   = 4,
  parameter int TC_N   = 8,
  parameter int RID_W  = 24,
  parameter int SLOT_W = 3,
  parameter int IMPL_W = 50
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ins_en,
  input  logic                ins_tr,
  input  logic [SLOT_W-1:0]   ins_slot,
  input  logic [63:0]         ins_va,
  input  logic [RID_W-1:0]    ins_rid,
  input  logic [63:0]         ins_pte0,
  input  logic [63:0]         ins_pte1,
  input  logic                pg_en,
  input  logic [RID_W-1:0]    pg_rid,
  input  logic [63:0]         pg_va,
  input  logic [5:0]          pg_log2sz,
  input  logic [63:0]         lk_va,
  input  logic [RID_W-1:0]    lk_rid,
  output logic [63:0]         lk_key,
  input  logic [63:0]         pp_va,
  input  logic [RID_W-1:0]    pp_rid,
  input  logic [1:0]          pp_cur_pl,
  output logic [1:0]          pp_new_pl
);
  localparam int N = TR_N + TC_N;

  logic [N-1:0]        e_valid;
  logic [RID_W-1:0]    e_rid  [N];
  logic [XB_VA_W-1:0]  e_va   [N];
  logic [XB_PTE_W-1:0] e_pte0 [N];
  logic [XB_PTE_W-1:0] e_pte1 [N];

  xb_store #(.TR_N(TR_N), .TC_N(TC_N), .RID_W(RID_W), .SLOT_W(SLOT_W), .N(N)) u_store (
    .clk(clk), .rst(rst),
    .ins_en(ins_en), .ins_tr(ins_tr), .ins_slot(ins_slot), .ins_va(ins_va),
    .ins_rid(ins_rid), .ins_pte0(ins_pte0), .ins_pte1(ins_pte1),
    .pg_en(pg_en), .pg_rid(pg_rid), .pg_va(pg_va), .pg_log2sz(pg_log2sz),
    .e_valid(e_valid), .e_rid(e_rid), .e_va(e_va), .e_pte0(e_pte0), .e_pte1(e_pte1)
  );

  logic                key_hit, pro_hit;
  logic [XB_PTE_W-1:0] key_p0, key_p1, pro_p0, pro_p1;

  xb_lookup #(.N(N), .RID_W(RID_W)) u_key_lu (
    .clk(clk), .rst(rst), .e_valid(e_valid), .e_rid(e_rid), .e_va(e_va),
    .e_pte0(e_pte0), .e_pte1(e_pte1), .q_va(lk_va), .q_rid(lk_rid),
    .hit(key_hit), .pte0(key_p0), .pte1(key_p1)
  );

  xb_lookup #(.N(N), .RID_W(RID_W)) u_pro_lu (
    .clk(clk), .rst(rst), .e_valid(e_valid), .e_rid(e_rid), .e_va(e_va),
    .e_pte0(e_pte0), .e_pte1(e_pte1), .q_va(pp_va), .q_rid(pp_rid),
    .hit(pro_hit), .pte0(pro_p0), .pte1(pro_p1)
  );

  logic key_unimpl;
  assign key_unimpl = (lk_va >> IMPL_W) != '0;

  always_comb begin
    if (key_unimpl || !key_hit) begin
      lk_key = 64'd1;
    end else begin
      lk_key = '0;
      lk_key[P1_KEY_LO +: KEY_W] = key_p1[P1_KEY_LO +: KEY_W];
    end
  end

  logic [1:0] pg_pl;
  logic [2:0] pg_ar;
  assign pg_pl = pro_p0[P0_PL_LO +: 2];
  assign pg_ar = pro_p0[P0_AR_LO +: 3];

  always_comb begin
    pp_new_pl = pp_cur_pl;
    if (pro_hit && (pg_ar == AR_EXEC_ONLY) && (pg_pl < pp_cur_pl)) pp_new_pl = pg_pl;
  end

  // R11
  no_demote_chk: assert property (@(posedge clk) disable iff (rst) pp_new_pl <= pp_cur_pl);

  // R5
  key_field_chk: assert property (@(posedge clk) disable iff (rst)
    (lk_key[63:32] == '0) && (lk_key[7:1] == '0));

  // R6
  unimpl_sentinel_chk: assert property (@(posedge clk) disable iff (rst)
    ((lk_va >> IMPL_W) != '0) |-> (lk_key == 64'd1));
endmodule

// File: tb/xlat_buffer_bench.sv
`timescale 1ns/1ps
module xlat_buffer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ins_en = 1'b0, ins_tr = 1'b0;
  logic [2:0]  ins_slot = '0;
  logic [63:0] ins_va = '0, ins_pte0 = '0, ins_pte1 = '0;
  logic [23:0] ins_rid = '0;
  logic        pg_en = 1'b0;
  logic [23:0] pg_rid = '0;
  logic [63:0] pg_va = '0;
  logic [5:0]  pg_log2sz = 6'd12;
  logic [63:0] lk_va = '0;
  logic [23:0] lk_rid = '0;
  logic [63:0] lk_key;
  logic [63:0] pp_va = '0;
  logic [23:0] pp_rid = '0;
  logic [1:0]  pp_cur_pl = '0;
  logic [1:0]  pp_new_pl;

  always #2.5 clk = ~clk;

  xlat_buffer u_xlat_buffer (
    .clk(clk), .rst(rst), .ins_en(ins_en), .ins_tr(ins_tr), .ins_slot(ins_slot),
    .ins_va(ins_va), .ins_rid(ins_rid), .ins_pte0(ins_pte0), .ins_pte1(ins_pte1),
    .pg_en(pg_en), .pg_rid(pg_rid), .pg_va(pg_va), .pg_log2sz(pg_log2sz),
    .lk_va(lk_va), .lk_rid(lk_rid), .lk_key(lk_key),
    .pp_va(pp_va), .pp_rid(pp_rid), .pp_cur_pl(pp_cur_pl), .pp_new_pl(pp_new_pl)
  );

  int n_chk = 0, n_bad = 0;
  localparam logic [63:0] BASE = 64'h0000_1234_0000_0000;

  // reference entries: 0..3 pinned, 4..11 cache
  logic        m_v   [12];
  logic [23:0] m_rid [12];
  logic [63:0] m_va  [12];
  logic [63:0] m_p0  [12];
  logic [63:0] m_p1  [12];

  function automatic int shf(input logic [1:0] c);
    return (c == 2'd3) ? 20 : 12 + 2 * int'(c);
  endfunction

  function automatic logic [63:0] mk0(input logic p, input logic [1:0] pl, input logic [2:0] ar);
    return {52'b0, ar, pl, 6'b0, p};
  endfunction

  function automatic logic [63:0] mk1(input logic [23:0] key, input logic [1:0] sz);
    return {32'b0, key, 6'b0, sz};
  endfunction

  function automatic int m_find(input logic [63:0] va, input logic [23:0] rid);
    for (int i = 0; i < 12; i++)
      if (m_v[i] && m_p0[i][0] && m_rid[i] == rid && ((va ^ m_va[i]) >> shf(m_p1[i][1:0])) == 0)
        return i;
    return -1;
  endfunction

  function automatic logic [63:0] m_key(input logic [63:0] va, input logic [23:0] rid);
    int k;
    if ((va >> 50) != 0) return 64'd1;
    k = m_find(va, rid);
    if (k < 0) return 64'd1;
    return {32'b0, m_p1[k][31:8], 8'b0};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic m_purge(input logic [23:0] rid, input logic [63:0] va, input logic [5:0] l2);
    bit ok;
    int rs, s;
    ok = (l2 == 12 || l2 == 14 || l2 == 16 || l2 == 20);
    rs = int'(l2);
    for (int i = 4; i < 12; i++) begin
      s = shf(m_p1[i][1:0]);
      if (s < rs) s = rs;
      if (!ok) m_v[i] = 1'b0;
      else if (m_rid[i] == rid && ((va ^ m_va[i]) >> s) == 0) m_v[i] = 1'b0;
    end
  endtask

  task automatic m_ins(input bit tr, input logic [2:0] slot, input logic [63:0] va,
                       input logic [23:0] rid, input logic [63:0] p0, input logic [63:0] p1);
    int k;
    k = tr ? int'(slot[1:0]) : 4 + int'(slot);
    m_v[k] = 1'b1; m_rid[k] = rid; m_va[k] = va; m_p0[k] = p0; m_p1[k] = p1;
  endtask

  task automatic cmd(input bit do_ins, input bit tr, input logic [2:0] slot,
                     input logic [63:0] va, input logic [23:0] rid,
                     input logic [63:0] p0, input logic [63:0] p1,
                     input bit do_pg, input logic [23:0] prid,
                     input logic [63:0] pva, input logic [5:0] l2);
    @(negedge clk);
    ins_en = do_ins; ins_tr = tr; ins_slot = slot; ins_va = va; ins_rid = rid;
    ins_pte0 = p0; ins_pte1 = p1;
    pg_en = do_pg; pg_rid = prid; pg_va = pva; pg_log2sz = l2;
    @(negedge clk);
    ins_en = 1'b0; pg_en = 1'b0;
    if (do_pg) m_purge(prid, pva, l2);
    if (do_ins) m_ins(tr, slot, va, rid, p0, p1);
  endtask

  task automatic ins(input bit tr, input logic [2:0] slot, input logic [63:0] va,
                     input logic [23:0] rid, input logic [63:0] p0, input logic [63:0] p1);
    cmd(1'b1, tr, slot, va, rid, p0, p1, 1'b0, '0, '0, 6'd12);
  endtask

  task automatic purge(input logic [23:0] rid, input logic [63:0] va, input logic [5:0] l2);
    cmd(1'b0, 1'b0, '0, '0, '0, '0, '0, 1'b1, rid, va, l2);
  endtask

  task automatic key_at(input string req, input logic [63:0] va, input logic [23:0] rid);
    lk_va = va; lk_rid = rid;
    #1;
    check(req, lk_key, m_key(va, rid));
  endtask

  // 128 addresses, 0x3000 apart, crossing every size boundary and one 1 MB boundary
  task automatic sweep(input string req);
    for (int i = 0; i < 128; i++)
      key_at(req, BASE + 64'(i) * 64'h3000 + 64'h100, (i % 3 == 0) ? 24'd6 : 24'd5);
    key_at(req, BASE + 64'h5000, 24'd5);
    key_at(req, BASE + 64'h8000, 24'd5);
    key_at(req, BASE + 64'h41000, 24'd5);
    key_at(req, BASE + 64'h100000, 24'd6);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 12; i++) begin
      m_v[i] = 1'b0; m_rid[i] = '0; m_va[i] = '0; m_p0[i] = '0; m_p1[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    sweep("R1");

    // R2 R3 R4 R5 R7: mixed sizes, overlaps, absent entry, shadowed matches
    ins(1'b1, 3'd0, BASE + 64'h5000,   24'd5, mk0(1, 0, 0), mk1(24'h111111, 2'd0));
    ins(1'b1, 3'd1, BASE + 64'h10000,  24'd5, mk0(1, 0, 0), mk1(24'h222222, 2'd2));
    ins(1'b0, 3'd0, BASE + 64'h8000,   24'd5, mk0(1, 0, 0), mk1(24'h333333, 2'd1));
    ins(1'b0, 3'd3, BASE + 64'h100000, 24'd6, mk0(1, 0, 0), mk1(24'h444444, 2'd3));
    ins(1'b0, 3'd5, BASE + 64'h12000,  24'd5, mk0(1, 0, 0), mk1(24'h555555, 2'd0));
    ins(1'b0, 3'd1, BASE + 64'h40000,  24'd5, mk0(0, 0, 0), mk1(24'h666666, 2'd2));
    ins(1'b0, 3'd2, BASE + 64'h41000,  24'd5, mk0(1, 0, 0), mk1(24'h777777, 2'd0));
    ins(1'b0, 3'd6, BASE + 64'h8000,   24'd5, mk0(1, 0, 0), mk1(24'h888888, 2'd0));
    sweep("R4");
    // R7 pinned beats cache at 0x12000, lower cache slot wins at 0x8000
    key_at("R7", BASE + 64'h12000, 24'd5);
    key_at("R7", BASE + 64'h8800, 24'd5);
    // R6 unimplemented address with a matching entry
    ins(1'b1, 3'd2, 64'h0008_0000_0000_0000, 24'd5, mk0(1, 0, 0), mk1(24'h999999, 2'd0));
    lk_va = 64'h0008_0000_0000_0010; lk_rid = 24'd5; #1;
    check("R6", lk_key, 64'd1);
    // R2 overwrite and slot wrap (slot 5 lands on pinned slot 1)
    ins(1'b1, 3'd0, BASE + 64'h5000, 24'd5, mk0(1, 0, 0), mk1(24'hABCDEF, 2'd0));
    ins(1'b1, 3'd5, BASE + 64'h10000, 24'd5, mk0(1, 0, 0), mk1(24'h0F0F0F, 2'd2));
    key_at("R2", BASE + 64'h5123, 24'd5);
    key_at("R2", BASE + 64'h1F000, 24'd5);
    sweep("R2");

    // R8 purges: region mismatch, small request inside a large entry, large request
    purge(24'd7, BASE + 64'h100000, 6'd20);
    sweep("R8");
    purge(24'd5, BASE + 64'h9000, 6'd12);
    sweep("R8");
    purge(24'd6, BASE + 64'h150000, 6'd16);
    sweep("R8");
    purge(24'd5, BASE + 64'h40000, 6'd20);
    sweep("R8");

    // R9 unsupported size clears the whole cache section
    ins(1'b0, 3'd4, BASE + 64'h30000, 24'd5, mk0(1, 0, 0), mk1(24'h123456, 2'd0));
    ins(1'b0, 3'd7, BASE + 64'h60000, 24'd6, mk0(1, 0, 0), mk1(24'h654321, 2'd3));
    sweep("R9");
    purge(24'd1, 64'h0, 6'd13);
    key_at("R9", BASE + 64'h30000, 24'd5);
    key_at("R9", BASE + 64'h60000, 24'd6);
    sweep("R9");

    // R10 insert and flush in the same cycle
    cmd(1'b1, 1'b0, 3'd4, BASE + 64'h30000, 24'd5, mk0(1, 0, 0), mk1(24'h0A0B0C, 2'd0),
        1'b1, 24'd5, 64'h0, 6'd40);
    key_at("R10", BASE + 64'h30000, 24'd5);
    sweep("R10");

    // R11 every page level x rights x current level
    for (int pl = 0; pl < 4; pl++) begin
      for (int a = 0; a < 2; a++) begin
        logic [2:0] ar;
        ar = (a == 0) ? 3'd7 : 3'd3;
        ins(1'b1, 3'd3, 64'h0000_0000_7700_0000, 24'd9, mk0(1, 2'(pl), ar), mk1(24'h1, 2'd0));
        for (int c = 0; c < 4; c++) begin
          pp_va = 64'h0000_0000_7700_0040; pp_rid = 24'd9; pp_cur_pl = 2'(c); #1;
          check("R11", 64'(pp_new_pl), 64'(((ar == 3'd7) && (pl < c)) ? pl : c));
          pp_va = 64'h0000_0000_7701_0040; #1;
          check("R11", 64'(pp_new_pl), 64'(c));
        end
      end
    end

    // R1 reset again empties both sections
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 12; i++) m_v[i] = 1'b0;
    key_at("R1", BASE + 64'h5000, 24'd5);
    sweep("R1");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule